// File: doc/BRIEF.md
# Audio Oversampling Clock Divider

This block turns a core clock that already runs at a fixed multiple of the audio sample rate (fs) into the timing enables an audio serial port needs. A family select input picks whether the core clock is 512 times or 384 times fs. A 3-bit shift code then picks the master clock as the core clock divided by a power of two. The block also supplies a bit-clock enable, with 32 or 48 bit slots per frame, and a one-cycle frame strobe once per fs period. The core clock itself is generated elsewhere.

All outputs are synchronous to the core clock. The master clock is offered two ways. One is a 50% duty level. The other is a one-cycle enable at the start of each master clock period. Both come from one phase counter, which restarts at zero every time the run input is taken high. When run is low, every timing output is held low. A family and shift code combination that has no valid ratio raises a configuration error. That error holds the master clock outputs low, while frame and bit timing carry on.

Top module: `audclk_div`

## Requirements
- R1: While reset is asserted, mclk_o, mclk_tick_o, bclk_tick_o and fs_stb_o are all low.
- R2: With base_sel_i = 0 the core clock is taken as 512·fs. fs_stb_o pulses for one cycle every 512 cycles. The first pulse comes in the first cycle after run_i is sampled high.
- R3: With base_sel_i = 1 the core clock is taken as 384·fs, and fs_stb_o pulses for one cycle every 384 cycles.
- R4: Let P = 2^mult_code_i. mclk_tick_o pulses in every cycle whose frame phase (0 at the fs_stb_o cycle) is a multiple of P. This gives master clock ratios of 512/256/128/64/32·fs for codes 0..4 with base_sel_i = 0, and 384/192/96/48·fs for codes 0..3 with base_sel_i = 1.
- R5: For codes above 0, mclk_o is high during the first P/2 cycles of each master clock period and low during the rest, which is 50% duty. For code 0, mclk_o stays low and mclk_tick_o is high on every running cycle.
- R6: Let K be 32 when wide_bclk_i = 0 and 48 when it is 1, and let N be the frame length. bclk_tick_o is high at frame phase p exactly when floor((p+1)·K/N) > floor(p·K/N). This gives exactly K bit ticks per frame and none at phase 0.
- R7: cfg_err_o is high whenever the shift code exceeds 4 with base_sel_i = 0, or exceeds 3 with base_sel_i = 1. While it is high, mclk_o and mclk_tick_o stay low, and fs_stb_o and bclk_tick_o continue.
- R8: In the cycle after run_i is sampled low, all four timing outputs are low. On the next rise of run_i, timing restarts at frame phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock (512·fs or 384·fs) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Enables all timing outputs; a rise restarts the frame |
| base_sel_i | input | 1 | 0: core clock is 512·fs, 1: core clock is 384·fs |
| mult_code_i | input | CODE_W (3) | Master clock shift code, divide by 2^code |
| wide_bclk_i | input | 1 | 0: 32 bit slots per frame, 1: 48 bit slots per frame |
| mclk_o | output | 1 | Master clock level, 50% duty |
| mclk_tick_o | output | 1 | One-cycle enable at each master clock period start |
| bclk_tick_o | output | 1 | Bit clock enable |
| fs_stb_o | output | 1 | Frame strobe, one cycle per fs period |
| cfg_err_o | output | 1 | Illegal family and shift code combination |

## Verification
Both families are run with the smallest and largest legal shift codes and a middle code. This separates the power-of-two division from the frame length, and code 0 isolates the pass-through corner of the duty output. Each family is paired with both bit slot counts. On the 384 base the bit ticks are evenly spaced, and 48 slots on the 512 base forces the fractional spacing. Code 4 on the 384 base and code 5 on the 512 base test the illegal decode against the legal code 4 on the 512 base. A mid-frame stop and restart shows that the phase returns to zero instead of continuing.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

   typedef enum logic {
      FAMILY_HI = 1'b0,
      FAMILY_LO = 1'b1
   } family_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/audclk_cfg_decode.sv
module audclk_cfg_decode
   import audclk_pkg::*;
#(
   parameter int BASE_HI      = 512,
   parameter int BASE_LO      = 384,
   parameter int MIN_RATIO_HI = 32,
   parameter int MIN_RATIO_LO = 48,
   parameter int BITS_STD     = 32,
   parameter int BITS_WIDE    = 48,
   parameter int CODE_W       = 3,
   parameter int CNT_W        = 9,
   parameter int ACC_W        = 10
) (
   input  logic              base_sel_i,
   input  logic [CODE_W-1:0] mult_code_i,
   input  logic              wide_bclk_i,
   output logic              legal_o,
   output logic [CNT_W-1:0]  frame_last_o,
   output logic [ACC_W-1:0]  frame_len_o,
   output logic [CNT_W-1:0]  sub_mask_o,
   output logic [ACC_W-1:0]  bits_o
);
   localparam int MAXC_HI = $clog2(BASE_HI / MIN_RATIO_HI);
   localparam int MAXC_LO = $clog2(BASE_LO / MIN_RATIO_LO);
   localparam int NCODES  = 2 ** CODE_W;

   logic [CNT_W-1:0] mask_tab [NCODES];

   // one low-bit mask per shift code; codes beyond the counter saturate
   for (genvar g = 0; g < NCODES; g++) begin : g_mask
      localparam int MV = (g >= CNT_W) ? (2 ** CNT_W) - 1 : (2 ** g) - 1;
      assign mask_tab[g] = CNT_W'(MV);
   end

   family_e fam;

   always_comb begin
      fam = family_e'(base_sel_i);
      if (fam == FAMILY_LO) begin
         legal_o      = int'(mult_code_i) <= MAXC_LO;
         frame_last_o = CNT_W'(BASE_LO - 1);
         frame_len_o  = ACC_W'(BASE_LO);
      end else begin
         legal_o      = int'(mult_code_i) <= MAXC_HI;
         frame_last_o = CNT_W'(BASE_HI - 1);
         frame_len_o  = ACC_W'(BASE_HI);
      end
      sub_mask_o = mask_tab[mult_code_i];
      bits_o     = wide_bclk_i ? ACC_W'(BITS_WIDE) : ACC_W'(BITS_STD);
   end

endmodule

// File: rtl/audclk_phase_ctr.sv
module audclk_phase_ctr #(
   parameter int CNT_W = 9
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [CNT_W-1:0] last_i,
   output logic             live_o,
   output logic [CNT_W-1:0] cnt_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         live_o <= 1'b0;
         cnt_o  <= '0;
      end else if (!run_i) begin
         live_o <= 1'b0;
         cnt_o  <= '0;
      end else begin
         live_o <= 1'b1;
         if (live_o) begin
            cnt_o <= (cnt_o >= last_i) ? '0 : cnt_o + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/audclk_mclk_gen.sv
module audclk_mclk_gen #(
   parameter int CNT_W = 9
) (
   input  logic             live_i,
   input  logic             legal_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] mask_i,
   output logic             mclk_o,
   output logic             tick_o
);
   logic [CNT_W-1:0] half;
   logic             active;

   always_comb begin
      half   = (mask_i >> 1) + CNT_W'(1);
      active = live_i & legal_i;
      tick_o = active & ((cnt_i & mask_i) == '0);
      mclk_o = active & (mask_i != '0) & ((cnt_i & half) == '0);
   end

endmodule

// File: rtl/audclk_bclk_acc.sv
module audclk_bclk_acc #(
   parameter int ACC_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             live_i,
   input  logic [ACC_W-1:0] bits_i,
   input  logic [ACC_W-1:0] len_i,
   output logic             tick_o
);
   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] sum;
   logic             hit;

   always_comb begin
      sum    = acc + bits_i;
      hit    = sum >= len_i;
      tick_o = live_i & hit;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc <= '0;
      end else if (!run_i || !live_i) begin
         acc <= '0;
      end else begin
         acc <= hit ? sum - len_i : sum;
      end
   end

endmodule

// File: rtl/audclk_div.sv
module audclk_div
   import audclk_pkg::*;
#(
   parameter int BASE_HI      = 512,
   parameter int BASE_LO      = 384,
   parameter int MIN_RATIO_HI = 32,
   parameter int MIN_RATIO_LO = 48,
   parameter int BITS_STD     = 32,
   parameter int BITS_WIDE    = 48,
   parameter int CODE_W       = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic              base_sel_i,
   input  logic [CODE_W-1:0] mult_code_i,
   input  logic              wide_bclk_i,
   output logic              mclk_o,
   output logic              mclk_tick_o,
   output logic              bclk_tick_o,
   output logic              fs_stb_o,
   output logic              cfg_err_o
);
   localparam int CNT_W = $clog2(BASE_HI);
   localparam int ACC_W = CNT_W + 1;

   if (!is_pow2(BASE_HI / MIN_RATIO_HI) || (BASE_HI % MIN_RATIO_HI) != 0) begin : g_bad_hi
      $error("BASE_HI must be a power-of-two multiple of MIN_RATIO_HI");
   end
   if (!is_pow2(BASE_LO / MIN_RATIO_LO) || (BASE_LO % MIN_RATIO_LO) != 0) begin : g_bad_lo
      $error("BASE_LO must be a power-of-two multiple of MIN_RATIO_LO");
   end
   if (BASE_LO >= BASE_HI) begin : g_bad_order
      $error("BASE_LO must be below BASE_HI");
   end
   if (BITS_STD >= BASE_LO || BITS_WIDE >= BASE_LO) begin : g_bad_bits
      $error("bit slots per frame must be below the shorter frame length");
   end
   if ($clog2(BASE_HI / MIN_RATIO_HI) >= 2 ** CODE_W) begin : g_bad_code
      $error("CODE_W too narrow for the largest shift");
   end

   logic             legal;
   logic [CNT_W-1:0] frame_last;
   logic [ACC_W-1:0] frame_len;
   logic [CNT_W-1:0] sub_mask;
   logic [ACC_W-1:0] bits;
   logic             live;
   logic [CNT_W-1:0] cnt;

   audclk_cfg_decode #(
      .BASE_HI(BASE_HI), .BASE_LO(BASE_LO),
      .MIN_RATIO_HI(MIN_RATIO_HI), .MIN_RATIO_LO(MIN_RATIO_LO),
      .BITS_STD(BITS_STD), .BITS_WIDE(BITS_WIDE),
      .CODE_W(CODE_W), .CNT_W(CNT_W), .ACC_W(ACC_W)
   ) decode_i (
      .base_sel_i  (base_sel_i),
      .mult_code_i (mult_code_i),
      .wide_bclk_i (wide_bclk_i),
      .legal_o     (legal),
      .frame_last_o(frame_last),
      .frame_len_o (frame_len),
      .sub_mask_o  (sub_mask),
      .bits_o      (bits)
   );

   audclk_phase_ctr #(.CNT_W(CNT_W)) phase_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (run_i),
      .last_i(frame_last),
      .live_o(live),
      .cnt_o (cnt)
   );

   audclk_mclk_gen #(.CNT_W(CNT_W)) mclk_i (
      .live_i (live),
      .legal_i(legal),
      .cnt_i  (cnt),
      .mask_i (sub_mask),
      .mclk_o (mclk_o),
      .tick_o (mclk_tick_o)
   );

   audclk_bclk_acc #(.ACC_W(ACC_W)) bclk_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (run_i),
      .live_i(live),
      .bits_i(bits),
      .len_i (frame_len),
      .tick_o(bclk_tick_o)
   );

   assign fs_stb_o  = live & (cnt == '0);
   assign cfg_err_o = ~legal;

endmodule

// File: rtl/audclk_div_chk.sv
module audclk_div_chk #(
   parameter int BASE_HI = 512,
   parameter int BASE_LO = 384,
   parameter int CODE_W  = 3
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              run_i,
   input logic              base_sel_i,
   input logic [CODE_W-1:0] mult_code_i,
   input logic              mclk_o,
   input logic              mclk_tick_o,
   input logic              bclk_tick_o,
   input logic              fs_stb_o,
   input logic              cfg_err_o
);
   logic        armed;
   logic [15:0] gap;
   logic [15:0] n_cyc;

   assign n_cyc = base_sel_i ? 16'(BASE_LO) : 16'(BASE_HI);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed <= 1'b0;
         gap   <= '0;
      end else if (!run_i) begin
         armed <= 1'b0;
         gap   <= '0;
      end else if (fs_stb_o) begin
         armed <= 1'b1;
         gap   <= 16'd1;
      end else if (armed) begin
         gap <= gap + 16'd1;
      end
   end

   AST_QUIET_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (!fs_stb_o && !mclk_o && !mclk_tick_o && !bclk_tick_o)); // R8
   AST_FIRST_FRAME_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(run_i) |=> fs_stb_o); // R2
   AST_FRAME_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && gap == n_cyc) |-> fs_stb_o); // R3
   AST_FRAME_NOT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && fs_stb_o) |-> gap == n_cyc); // R3
   AST_ILLEGAL_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_err_o |-> (!mclk_o && !mclk_tick_o)); // R7
   AST_FRAME_START_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fs_stb_o && !cfg_err_o) |-> mclk_tick_o); // R4
   AST_MCLK_HIGH_AT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mclk_tick_o && mult_code_i != '0) |-> mclk_o); // R5
   AST_BCLK_OFF_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fs_stb_o |-> !bclk_tick_o); // R6

endmodule

bind audclk_div audclk_div_chk #(
   .BASE_HI(BASE_HI), .BASE_LO(BASE_LO), .CODE_W(CODE_W)
) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .run_i      (run_i),
   .base_sel_i (base_sel_i),
   .mult_code_i(mult_code_i),
   .mclk_o     (mclk_o),
   .mclk_tick_o(mclk_tick_o),
   .bclk_tick_o(bclk_tick_o),
   .fs_stb_o   (fs_stb_o),
   .cfg_err_o  (cfg_err_o)
);

// File: tb/audclk_div_tb_top.sv
module audclk_div_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic       base = 1'b0;
   logic       wide = 1'b0;
   logic [2:0] code = 3'd0;
   logic       mclk, mtick, btick, fs, err;

   always #(CLK_PERIOD / 2) clk = ~clk;

   audclk_div dut_i (
      .clk_i(clk), .rst_ni(rst_n), .run_i(run), .base_sel_i(base),
      .mult_code_i(code), .wide_bclk_i(wide),
      .mclk_o(mclk), .mclk_tick_o(mtick), .bclk_tick_o(btick),
      .fs_stb_o(fs), .cfg_err_o(err)
   );

   typedef struct packed {
      logic live; logic base; logic fs; logic mt; logic mo; logic bt; logic err;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   m_live = 1'b0;
   int   m_cnt = 0;
   int   n_fs, n_mt, n_mo, n_bt;

   task automatic check_bit(string tag, string what, logic got, logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got %0b expected %0b at %0t", tag, what, got, exp, $time);
      end
   endtask

   task automatic check_int(string tag, string what, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and queues what must follow the next edge
   task automatic step(bit r, bit b, logic [2:0] c, bit w);
      int   n, k, maxc, p;
      bit   legal;
      exp_t e;
      @(negedge clk);
      run = r; base = b; code = c; wide = w;
      n = b ? 384 : 512;
      k = w ? 48 : 32;
      maxc = b ? 3 : 4;
      legal = int'(c) <= maxc;
      p = 1 << c;
      if (!r) begin
         m_live = 1'b0; m_cnt = 0;
      end else if (!m_live) begin
         m_live = 1'b1; m_cnt = 0;
      end else begin
         m_cnt = (m_cnt == n - 1) ? 0 : m_cnt + 1;
      end
      e.live = m_live;
      e.base = b;
      e.fs   = m_live && (m_cnt == 0);
      e.mt   = m_live && legal && ((m_cnt % p) == 0);
      e.mo   = m_live && legal && (c != 0) && ((m_cnt % p) < p / 2);
      e.bt   = m_live && ((((m_cnt + 1) * k) / n) != ((m_cnt * k) / n));
      e.err  = !legal;
      q.push_back(e);
   endtask

   // monitor: compares the outputs after each edge against the queued expectation
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            e = q.pop_front();
            if (!e.live) begin
               check_bit("R8", "fs_stb idle", fs, e.fs);
               check_bit("R8", "mclk idle", mclk, e.mo);
               check_bit("R8", "mclk_tick idle", mtick, e.mt);
               check_bit("R8", "bclk_tick idle", btick, e.bt);
            end else begin
               check_bit(e.base ? "R3" : "R2", "fs_stb", fs, e.fs);
               check_bit(e.err ? "R7" : "R4", "mclk_tick", mtick, e.mt);
               check_bit(e.err ? "R7" : "R5", "mclk level", mclk, e.mo);
               check_bit("R6", "bclk_tick", btick, e.bt);
            end
            check_bit("R7", "cfg_err", err, e.err);
            n_fs += int'(fs); n_mt += int'(mtick);
            n_mo += int'(mclk); n_bt += int'(btick);
         end
      end
   end

   // two whole frames, then frame-level totals
   task automatic segment(bit b, logic [2:0] c, bit w);
      int  n, k, p;
      bit  legal;
      string tf;
      n = b ? 384 : 512;
      k = w ? 48 : 32;
      p = 1 << c;
      legal = int'(c) <= (b ? 3 : 4);
      tf = b ? "R3" : "R2";
      repeat (3) step(1'b0, b, c, w);
      n_fs = 0; n_mt = 0; n_mo = 0; n_bt = 0;
      repeat (2 * n) step(1'b1, b, c, w);
      repeat (2) step(1'b0, b, c, w);
      check_int(tf, "frame strobes in two frames", n_fs, 2);
      check_int(legal ? "R4" : "R7", "master ticks in two frames", n_mt, legal ? 2 * n / p : 0);
      check_int(legal ? "R5" : "R7", "master high cycles in two frames", n_mo,
                (legal && c != 0) ? n : 0);
      check_int("R6", "bit ticks in two frames", n_bt, 2 * k);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog got 150000 cycles expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_bit("R1", "fs_stb in reset", fs, 1'b0);
      check_bit("R1", "mclk in reset", mclk, 1'b0);
      check_bit("R1", "mclk_tick in reset", mtick, 1'b0);
      check_bit("R1", "bclk_tick in reset", btick, 1'b0);
      rst_n = 1'b1;

      segment(1'b0, 3'd0, 1'b0);   // R2 R5 pass-through corner
      segment(1'b0, 3'd1, 1'b1);   // R4 R6 fractional bit spacing
      segment(1'b0, 3'd4, 1'b0);   // R4 largest legal shift on 512 base
      segment(1'b1, 3'd0, 1'b1);   // R3 R6
      segment(1'b1, 3'd3, 1'b0);   // R4 largest legal shift on 384 base
      segment(1'b1, 3'd2, 1'b1);   // R5
      segment(1'b1, 3'd4, 1'b1);   // R7 illegal on 384 base
      segment(1'b0, 3'd5, 1'b0);   // R7 illegal on 512 base

      // R8: stop mid-frame, then restart from phase 0
      repeat (3) step(1'b0, 1'b0, 3'd2, 1'b1);
      repeat (100) step(1'b1, 1'b0, 3'd2, 1'b1);
      repeat (2) step(1'b0, 1'b0, 3'd2, 1'b1);
      repeat (600) step(1'b1, 1'b0, 3'd2, 1'b1);
      repeat (3) step(1'b0, 1'b0, 3'd2, 1'b1);

      while (q.size() > 0) @(negedge clk);
      @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule